// File: doc/BRIEF.md
# Set/Clear Parallel Port

This block is a small general-purpose I/O port that sits next to serial channels on a shared byte-wide register bus. It has eight input pins and eight output pins, and both sets of pins are active low. The input pins pass through a synchronizer and can be read at one bus offset. The output levels come from an output register that software never writes directly. One offset ORs the written byte into the register and a second offset clears the bits marked in the written byte. Software can therefore change single lines without a read-modify-write sequence.

A per-bit routing byte is written at the same offset that reads the inputs. A zero bit leaves the pin under control of the output register. A one bit hands the pin to a special-function source, which in this build is a stub input vector. An active-low reset is synchronized inside the block. While reset is asserted, the output register and the routing byte are cleared, so every output pin rests high.

Top module: `pio_setclr_port`

## Requirements
- R1: While reset is asserted and after it is released, the output register and the routing byte are zero, every `pin_out_n` bit is 1, and a read of offset 0xD returns 0xFF while the pins are held high.
- R2: A bus write to offset 0xE sets to 1 every output-register bit whose data bit is 1 and leaves all other bits unchanged. The pins reflect the change in the cycle after the write edge.
- R3: A bus write to offset 0xF clears to 0 every output-register bit whose data bit is 1 and leaves all other bits unchanged.
- R4: When a routing bit is 0, the matching `pin_out_n` bit is the complement of the output-register bit, so a register bit of 1 drives the pin low.
- R5: When a routing bit is 1, the matching `pin_out_n` bit equals `alt_fn_in` of the same index and follows it combinationally. Clearing the routing bit restores the register-driven level, because the register is kept while the pin is routed away.
- R6: A read at offset 0xD returns the raw `pin_in_n` levels after two synchronizer flops. A pin change made between edges appears after the second rising edge and is not visible after the first.
- R7: Writes to offsets other than 0xD, 0xE and 0xF change neither the output register nor the routing byte. A read at any offset other than 0xD, or with `bus_rd` low, returns 0.
- R8: A write to offset 0xD loads the written byte into the routing byte and leaves the output register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| pin_in_n | input | 8 | Active-low input pins |
| alt_fn_in | input | 8 | Special-function sources used for routed pins |
| pin_out_n | output | 8 | Active-low output pins |

## Verification
The bench uses the default parameters: a width of 8 and two synchronizer stages. With these values every bit of the routing byte can be exercised, as can a mix of routed and register-driven pins in one byte. Because there are exactly two stages, the bench can sample the synchronizer output after each edge separately, which exposes an input path that is one stage too short or too long. The set and clear patterns are chosen to overlap bits that are already set, so a set write that overwrote the register or a clear write that inverted it would show up at the pins.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned PIO_ADDR_W = 4;

  localparam logic [PIO_ADDR_W-1:0] PIO_OFS_IN_CFG = 4'hD;
  localparam logic [PIO_ADDR_W-1:0] PIO_OFS_SET    = 4'hE;
  localparam logic [PIO_ADDR_W-1:0] PIO_OFS_CLR    = 4'hF;

  typedef enum logic [1:0] {
    PIO_OP_NONE,
    PIO_OP_CFG,
    PIO_OP_SET,
    PIO_OP_CLR
  } pio_op_e;

  function automatic pio_op_e pio_decode(input logic wr, input logic [PIO_ADDR_W-1:0] addr);
    pio_op_e op;
    op = PIO_OP_NONE;
    if (wr) begin
      unique case (addr)
        PIO_OFS_IN_CFG: op = PIO_OP_CFG;
        PIO_OFS_SET:    op = PIO_OP_SET;
        PIO_OFS_CLR:    op = PIO_OP_CLR;
        default:        op = PIO_OP_NONE;
      endcase
    end
    return op;
  endfunction
endpackage

// File: rtl/pio_rst_sync.sv
module pio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins_raw,
  output logic [WIDTH-1:0] pins_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = pins_raw;
      end else begin : g_rest
        always_comb stage_d[s] = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign pins_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pio_out_regs.sv
module pio_out_regs
  import pio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pio_op_e          op,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] cfg_q
);
  logic [WIDTH-1:0] out_d;
  logic [WIDTH-1:0] cfg_d;
  logic             out_en;
  logic             cfg_en;

  always_comb begin
    out_en = (op == PIO_OP_SET) || (op == PIO_OP_CLR);
    cfg_en = (op == PIO_OP_CFG);
    out_d  = out_q;
    if (op == PIO_OP_SET)      out_d = out_q | wdata;
    else if (op == PIO_OP_CLR) out_d = out_q & ~wdata;
    cfg_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= '0;
    else if (out_en) out_q <= out_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (out_q == '0 && cfg_q == '0));

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op == PIO_OP_SET |=> ((out_q & $past(wdata)) == $past(wdata)) &&
                         ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op == PIO_OP_CLR |=> ((out_q & $past(wdata)) == '0) &&
                         ((out_q & ~$past(wdata)) == ($past(out_q) & ~$past(wdata))));

  assert_other_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op == PIO_OP_NONE |=> $stable(out_q) && $stable(cfg_q));

  assert_cfg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op == PIO_OP_CFG |=> $stable(out_q) && (cfg_q == $past(wdata)));
endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] out_reg,
  input  logic [WIDTH-1:0] route_sel,
  input  logic [WIDTH-1:0] alt_src,
  output logic [WIDTH-1:0] pins_n
);
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_comb begin
        if (route_sel[b]) pins_n[b] = alt_src[b];
        else              pins_n[b] = ~out_reg[b];
      end
    end
  endgenerate
endmodule

// File: rtl/pio_setclr_port.sv
module pio_setclr_port
  import pio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [PIO_ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]      bus_wdata,
  output logic [WIDTH-1:0]      bus_rdata,
  input  logic [WIDTH-1:0]      pin_in_n,
  input  logic [WIDTH-1:0]      alt_fn_in,
  output logic [WIDTH-1:0]      pin_out_n
);
  logic             rst_sync_n;
  logic [WIDTH-1:0] in_sync;
  logic [WIDTH-1:0] out_reg;
  logic [WIDTH-1:0] cfg_reg;
  pio_op_e          op;

  pio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  pio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_in (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pins_raw  (pin_in_n),
    .pins_sync (in_sync)
  );

  always_comb op = pio_decode(bus_wr, bus_addr);

  pio_out_regs #(.WIDTH(WIDTH)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .op    (op),
    .wdata (bus_wdata),
    .out_q (out_reg),
    .cfg_q (cfg_reg)
  );

  pio_pin_mux #(.WIDTH(WIDTH)) u_mux (
    .out_reg   (out_reg),
    .route_sel (cfg_reg),
    .alt_src   (alt_fn_in),
    .pins_n    (pin_out_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && bus_addr == PIO_OFS_IN_CFG) bus_rdata = in_sync;
  end
endmodule

// File: tb/tb_pio_setclr_port.sv
module tb_pio_setclr_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pin_in_n, alt_fn_in, pin_out_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [7:0] m_out, m_cfg;

  always #2 clk = ~clk;

  pio_setclr_port dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in_n(pin_in_n), .alt_fn_in(alt_fn_in), .pin_out_n(pin_out_n)
  );

  function automatic logic [7:0] exp_pins();
    return (m_cfg & alt_fn_in) | (~m_cfg & ~m_out);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pins during reset", pin_out_n, 8'hFF);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_out = 8'h00; m_cfg = 8'h00;
    chk("R1 pins after reset", pin_out_n, 8'hFF);
    bus_read(4'hD, r);
    chk("R1 input read idle", r, 8'hFF);
  endtask

  task automatic t_set();
    bus_write(4'hE, 8'h81); m_out |= 8'h81;
    chk("R2 set 81", pin_out_n, exp_pins());
    bus_write(4'hE, 8'h25); m_out |= 8'h25;
    chk("R2 set overlapping 25", pin_out_n, exp_pins());
    chk("R4 complement A5", pin_out_n, 8'h5A);
  endtask

  task automatic t_clear();
    bus_write(4'hF, 8'h05); m_out &= ~8'h05;
    chk("R3 clear 05", pin_out_n, exp_pins());
    bus_write(4'hF, 8'h00);
    chk("R3 clear none", pin_out_n, exp_pins());
    bus_write(4'hE, 8'h05); m_out |= 8'h05;
    chk("R2 restore A5", pin_out_n, 8'h5A);
  endtask

  task automatic t_route();
    alt_fn_in = 8'h3C;
    bus_write(4'hD, 8'h0F); m_cfg = 8'h0F;
    chk("R8 cfg write keeps reg / R5 mixed", pin_out_n, exp_pins());
    @(negedge clk); alt_fn_in = 8'hC3; #1;
    chk("R5 alt follows", pin_out_n, exp_pins());
    bus_write(4'hF, 8'h01); m_out &= ~8'h01;
    chk("R5 routed pin ignores reg", pin_out_n, exp_pins());
    bus_write(4'hD, 8'h00); m_cfg = 8'h00;
    chk("R5 unroute restores reg", pin_out_n, ~m_out);
  endtask

  task automatic t_input();
    logic [7:0] r;
    @(negedge clk); pin_in_n = 8'h96;
    bus_read(4'hD, r);
    chk("R6 after one edge old", r, 8'hFF);
    bus_read(4'hD, r);
    chk("R6 after two edges new", r, 8'h96);
    @(negedge clk); pin_in_n = 8'h00;
    repeat (3) @(negedge clk);
    bus_read(4'hD, r);
    chk("R6 all low", r, 8'h00);
  endtask

  task automatic t_other();
    logic [7:0] r;
    bus_write(4'h3, 8'hFF);
    bus_write(4'h0, 8'hFF);
    bus_write(4'hC, 8'hFF);
    chk("R7 stray writes", pin_out_n, exp_pins());
    bus_read(4'hE, r);
    chk("R7 read other addr", r, 8'h00);
    @(negedge clk); bus_addr = 4'hD; #1;
    chk("R7 no strobe read", bus_rdata, 8'h00);
    alt_fn_in = 8'hFF; #1;
    chk("R7 cfg still zero", pin_out_n, ~m_out);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    pin_in_n = 8'hFF; alt_fn_in = 8'h00;
    m_out = 0; m_cfg = 0;
    t_reset();
    t_set();
    t_clear();
    t_route();
    t_input();
    t_other();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h01, 8'h00);
    finish_run();
  end
endmodule